// File: doc/BRIEF.md
# Flash Command-Map Decoder with Block Protection

This block sits between a register bus and a flash controller's data path. Every accepted 32-bit access carries a 26-bit address whose top two bits pick one of four maps. Two maps reach controller registers directly, and each of these scales the word index in its own way. One map reaches the flash data array. The last map is a command map, where the written value is an opcode and the rest of the address names a flash block, page and sector. Accesses that need the data path leave as a one-cycle request. Command-map writes are consumed inside the block.

The decoder keeps one protection bit per block, plus a second bit that marks a block as locked tight. Software changes protection with a start opcode written at the first block of a range, then an end opcode written at the last block. It can also issue a single unlock-all. Three sticky status bits report a protected-block hit, a finished protection operation and a malformed range. Software clears them through a write-one-to-acknowledge port.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all status bits read 0, no data-path request is pending, req_ready is 0 while reset is held and 1 from the first clock after release, and every block is locked with no block locked tight.
- R2: A request with map 0 (addr[25:24]=0) is forwarded with dp_addr = addr[23:1]. A request with map 3 is forwarded with dp_addr = addr[23:2]. In both cases dp_map equals the request's map.
- R3: A data-array request (map 1) to an unlocked block is forwarded with dp_addr = addr[23:0]. A read of a locked block is still forwarded. A write to a locked block is dropped. Any data-array access to a locked block sets status bit 0 (protected hit).
- R4: The block index is addr[12 +: log2(NBLK)] by default, with page at bit 6 and sector at bit 4. The parameter NARROW=1 moves them to bits 10, 4 and 2.
- R5: A command-map write of 0x08 at block S, followed by 0x09 at block E with E >= S, unlocks blocks S through E inclusive and sets status bit 1 (operation done).
- R6: The pair 0x0A then 0x0B locks blocks S through E inclusive and sets status bit 1.
- R7: The pair 0x0C then 0x0D locks blocks S through E and marks them tight. Tight blocks ignore unlock ranges and unlock-all until the next reset.
- R8: Writing 0x0E anywhere in the command map unlocks every block that is not tight and sets status bit 1.
- R9: An end opcode with no pending start, with a start of a different kind, or with E < S changes no protection, clears the pending start and sets status bit 2 (sequence error).
- R10: Opcode 0x03 (erase) at an unlocked block is forwarded as a map-2 write with the same address and data. At a locked block it is dropped and sets status bit 0.
- R11: An acknowledge clears exactly the status bits set in ack_data. A status event in the same cycle as its acknowledge leaves that bit set.
- R12: Command-map reads, command-map opcodes other than those listed, and values with any bit above bit 7 set have no effect on protection or status.
- R13: Each forwarded request appears on dp_valid for exactly one cycle, one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Map select [25:24] and flash address [23:0] |
| req_wdata | input | DW | Write data or command opcode |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_data | input | 3 | Status bits to clear |
| stat | output | 3 | Sticky status: bit0 protected hit, bit1 op done, bit2 sequence error |
| dp_valid | output | 1 | Data-path request pulse |
| dp_write | output | 1 | Data-path request direction |
| dp_map | output | 2 | Map of the forwarded request |
| dp_addr | output | 24 | Forwarded address or register word index |
| dp_wdata | output | DW | Forwarded write data |

## Verification
The assertions assume that req_valid and ack_valid are driven to known values on every clock after reset and that req_addr names a block below NBLK whenever the data-array or command map is selected. The stimulus only uses block numbers from 0 to 63 and changes inputs half a period away from the sampling edge. Range sequences are built on purpose to start, end, mismatch and invert, so the protection state at each step can be predicted from the requirements. It is then observed through forwarded or dropped data-array writes.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int NBLK   = 64,
  parameter bit NARROW = 1'b0,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [25:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ack_valid,
  input  logic [2:0]    ack_data,
  output logic [2:0]    stat,
  output logic          dp_valid,
  output logic          dp_write,
  output logic [1:0]    dp_map,
  output logic [23:0]   dp_addr,
  output logic [DW-1:0] dp_wdata
);
  localparam int IW     = $clog2(NBLK);
  localparam int BLK_SH = NARROW ? 10 : 12;

  localparam logic [7:0] OP_ERASE = 8'h03;
  localparam logic [7:0] OP_UNL_S = 8'h08;
  localparam logic [7:0] OP_UNL_E = 8'h09;
  localparam logic [7:0] OP_LCK_S = 8'h0A;
  localparam logic [7:0] OP_LCK_E = 8'h0B;
  localparam logic [7:0] OP_TGT_S = 8'h0C;
  localparam logic [7:0] OP_TGT_E = 8'h0D;
  localparam logic [7:0] OP_UNL_A = 8'h0E;

  logic [NBLK-1:0] lock_q, tight_q;
  logic            rdy_q, pend_q;
  logic [1:0]      kind_q;
  logic [IW-1:0]   start_q;
  logic [2:0]      stat_q;

  logic          acc, cmdw, op_ok, blk_lk, arr;
  logic [1:0]    map, s_kind, e_kind;
  logic [23:0]   faddr;
  logic [IW-1:0] blk;
  logic [7:0]    op;
  logic          is_start, is_end, end_ok, end_bad, unl_all, erase, lock_hit, fwd;

  assign acc    = req_valid & rdy_q;
  assign map    = req_addr[25:24];
  assign faddr  = req_addr[23:0];
  assign blk    = faddr[BLK_SH +: IW];
  assign op     = req_wdata[7:0];
  assign op_ok  = (req_wdata[DW-1:8] == '0);
  assign cmdw   = acc & req_write & (map == 2'd2) & op_ok;
  assign blk_lk = lock_q[blk];
  assign arr    = acc & (map == 2'd1);

  assign is_start = cmdw & (op == OP_UNL_S | op == OP_LCK_S | op == OP_TGT_S);
  assign is_end   = cmdw & (op == OP_UNL_E | op == OP_LCK_E | op == OP_TGT_E);
  assign s_kind   = (op == OP_UNL_S) ? 2'd0 : (op == OP_LCK_S) ? 2'd1 : 2'd2;
  assign e_kind   = (op == OP_UNL_E) ? 2'd0 : (op == OP_LCK_E) ? 2'd1 : 2'd2;
  assign end_ok   = is_end & pend_q & (kind_q == e_kind) & (blk >= start_q);
  assign end_bad  = is_end & ~end_ok;
  assign unl_all  = cmdw & (op == OP_UNL_A);
  assign erase    = cmdw & (op == OP_ERASE);
  assign lock_hit = (arr | erase) & blk_lk;
  assign fwd      = acc & ((map == 2'd0) | (map == 2'd3) |
                           (arr & ~(req_write & blk_lk)) | (erase & ~blk_lk));

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam logic [IW-1:0] GI = IW'(g);
    logic in_rng;
    assign in_rng = (GI >= start_q) & (GI <= blk);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_q[g]  <= 1'b1;
        tight_q[g] <= 1'b0;
      end else if (end_ok & in_rng) begin
        case (kind_q)
          2'd0:    if (!tight_q[g]) lock_q[g] <= 1'b0;
          2'd1:    lock_q[g] <= 1'b1;
          default: begin lock_q[g] <= 1'b1; tight_q[g] <= 1'b1; end
        endcase
      end else if (unl_all & ~tight_q[g]) begin
        lock_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      pend_q  <= 1'b0;
      kind_q  <= 2'd0;
      start_q <= '0;
      stat_q  <= '0;
    end else begin
      rdy_q  <= 1'b1;
      stat_q <= (stat_q & ~(ack_valid ? ack_data : 3'b000)) |
                {end_bad, end_ok | unl_all, lock_hit};
      if (is_start) begin
        pend_q  <= 1'b1;
        kind_q  <= s_kind;
        start_q <= blk;
      end else if (is_end) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_map   <= 2'd0;
      dp_addr  <= '0;
      dp_wdata <= '0;
    end else begin
      dp_valid <= fwd;
      if (fwd) begin
        dp_write <= req_write;
        dp_map   <= map;
        dp_wdata <= req_wdata;
        dp_addr  <= (map == 2'd0) ? {1'b0, faddr[23:1]} :
                    (map == 2'd3) ? {2'b00, faddr[23:2]} : faddr;
      end
    end
  end

  assign req_ready = rdy_q;
  assign stat      = stat_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NBLK   = 64,
  parameter bit NARROW = 1'b0,
  parameter int DW     = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [25:0]     req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic            ack_valid,
  input logic [2:0]      ack_data,
  input logic [2:0]      stat,
  input logic            dp_valid,
  input logic [NBLK-1:0] lock_q,
  input logic [NBLK-1:0] tight_q
);
  localparam int IW  = $clog2(NBLK);
  localparam int BSH = NARROW ? 10 : 12;

  logic          acc;
  logic [IW-1:0] bidx;
  assign acc  = req_valid && req_ready;
  assign bidx = req_addr[BSH +: IW];

  AST_DP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid |-> $past(acc)); // R13

  AST_LOCKED_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr[25:24] == 2'd1 && lock_q[bidx]) |=> (!dp_valid && stat[0])); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !acc) |=> ((stat & $past(ack_data)) == 3'b000)); // R11

  AST_TIGHT_IS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((tight_q & ~lock_q) == '0)); // R7

  AST_STAT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) != 3'b000) |-> $past(acc)); // R9

  AST_UNLOCK_ALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr[25:24] == 2'd2 && req_wdata == DW'(8'h0E)) |=> stat[1]); // R8
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NBLK(NBLK), .NARROW(NARROW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .ack_valid(ack_valid), .ack_data(ack_data), .stat(stat), .dp_valid(dp_valid),
  .lock_q(lock_q), .tight_q(tight_q)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_data = '0;
  logic        req_ready, dp_valid, dp_write;
  logic [2:0]  stat;
  logic [1:0]  dp_map;
  logic [23:0] dp_addr;
  logic [31:0] dp_wdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack_valid(ack_valid), .ack_data(ack_data), .stat(stat),
    .dp_valid(dp_valid), .dp_write(dp_write), .dp_map(dp_map),
    .dp_addr(dp_addr), .dp_wdata(dp_wdata)
  );

  typedef struct packed {
    logic        wr;
    logic [25:0] addr;
    logic [31:0] data;
    logic        dpv;
    logic [1:0]  dmap;
    logic [23:0] daddr;
    logic [2:0]  st;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 26'h1003000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd1},  // R1 all locked
    '{1'b0, 26'h1003000, 32'h0,  1'b1, 2'd1, 24'h003000, 3'b001, 8'd3},  // R3 locked read forwarded
    '{1'b1, 26'h2002000, 32'h08, 1'b0, 2'd0, 24'h0,      3'b000, 8'd5},
    '{1'b1, 26'h2005000, 32'h09, 1'b0, 2'd0, 24'h0,      3'b010, 8'd5},  // R5
    '{1'b1, 26'h1002040, 32'hAB, 1'b1, 2'd1, 24'h002040, 3'b000, 8'd5},
    '{1'b1, 26'h1005000, 32'hCD, 1'b1, 2'd1, 24'h005000, 3'b000, 8'd5},
    '{1'b1, 26'h1006000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd5},
    '{1'b1, 26'h2003000, 32'h0A, 1'b0, 2'd0, 24'h0,      3'b000, 8'd6},
    '{1'b1, 26'h2003000, 32'h0B, 1'b0, 2'd0, 24'h0,      3'b010, 8'd6},  // R6
    '{1'b1, 26'h1003000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd6},
    '{1'b1, 26'h1004000, 32'h0,  1'b1, 2'd1, 24'h004000, 3'b000, 8'd6},
    '{1'b1, 26'h2004000, 32'h0B, 1'b0, 2'd0, 24'h0,      3'b100, 8'd9},  // R9 no start
    '{1'b1, 26'h2006000, 32'h08, 1'b0, 2'd0, 24'h0,      3'b000, 8'd9},
    '{1'b1, 26'h2004000, 32'h09, 1'b0, 2'd0, 24'h0,      3'b100, 8'd9},  // R9 end below start
    '{1'b1, 26'h1006000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd9},
    '{1'b1, 26'h2007000, 32'h08, 1'b0, 2'd0, 24'h0,      3'b000, 8'd9},
    '{1'b1, 26'h2007000, 32'h0B, 1'b0, 2'd0, 24'h0,      3'b100, 8'd9},  // R9 kind mismatch
    '{1'b1, 26'h1007000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd9},
    '{1'b1, 26'h2002000, 32'h0C, 1'b0, 2'd0, 24'h0,      3'b000, 8'd7},
    '{1'b1, 26'h2002000, 32'h0D, 1'b0, 2'd0, 24'h0,      3'b010, 8'd7},  // R7
    '{1'b1, 26'h1002000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd7},
    '{1'b1, 26'h2000000, 32'h0E, 1'b0, 2'd0, 24'h0,      3'b010, 8'd8},  // R8
    '{1'b1, 26'h1002000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd7},
    '{1'b1, 26'h103F000, 32'h0,  1'b1, 2'd1, 24'h03F000, 3'b000, 8'd8},
    '{1'b1, 26'h2000000, 32'h08, 1'b0, 2'd0, 24'h0,      3'b000, 8'd7},
    '{1'b1, 26'h203F000, 32'h09, 1'b0, 2'd0, 24'h0,      3'b010, 8'd7},
    '{1'b1, 26'h1002000, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd7},
    '{1'b1, 26'h2009000, 32'h03, 1'b1, 2'd2, 24'h009000, 3'b000, 8'd10}, // R10 erase forwarded
    '{1'b1, 26'h2009000, 32'h0A, 1'b0, 2'd0, 24'h0,      3'b000, 8'd10},
    '{1'b1, 26'h2009000, 32'h0B, 1'b0, 2'd0, 24'h0,      3'b010, 8'd10},
    '{1'b1, 26'h2009000, 32'h03, 1'b0, 2'd0, 24'h0,      3'b001, 8'd10}, // R10 erase dropped
    '{1'b1, 26'h1009C00, 32'h0,  1'b0, 2'd0, 24'h0,      3'b001, 8'd4},  // R4 block field at bit 12
    '{1'b0, 26'h0000246, 32'h0,  1'b1, 2'd0, 24'h000123, 3'b000, 8'd2},  // R2 map 0
    '{1'b1, 26'h3000248, 32'h5,  1'b1, 2'd3, 24'h000092, 3'b000, 8'd2},  // R2 map 3
    '{1'b1, 26'h2001000, 32'h55, 1'b0, 2'd0, 24'h0,      3'b000, 8'd12}, // R12 unknown opcode
    '{1'b0, 26'h2014000, 32'h0A, 1'b0, 2'd0, 24'h0,      3'b000, 8'd12}, // R12 read ignored
    '{1'b1, 26'h2014000, 32'h10A,1'b0, 2'd0, 24'h0,      3'b000, 8'd12}, // R12 high bits set
    '{1'b1, 26'h2014000, 32'h0B, 1'b0, 2'd0, 24'h0,      3'b100, 8'd12}
  };

  task automatic req(input logic wr, input logic [25:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack(input logic [2:0] m);
    @(negedge clk);
    ack_valid = 1'b1; ack_data = m;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stat in reset", 64'(stat), 64'(0));
    chk("R1 ready in reset", 64'(req_ready), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'(1));
    chk("R1 dp idle", 64'(dp_valid), 64'(0));

    for (int i = 0; i < NV; i++) begin
      logic [63:0] a, e;
      req(VEC[i].wr, VEC[i].addr, VEC[i].data);
      a = {dp_valid, stat, (dp_valid ? {dp_map, dp_addr} : 26'h0)};
      e = {VEC[i].dpv, VEC[i].st, (VEC[i].dpv ? {VEC[i].dmap, VEC[i].daddr} : 26'h0)};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h", VEC[i].req, i, a, e);
      end
      ack(3'b111);
    end

    // R11 partial acknowledge and same-cycle set
    req(1'b1, 26'h1002000, 32'h0);
    req(1'b1, 26'h2000000, 32'h0E);
    chk("R11 both bits", 64'(stat), 64'(3'b011));
    ack(3'b010);
    chk("R11 partial ack", 64'(stat), 64'(3'b001));
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 26'h1002000; req_wdata = 0;
    ack_valid = 1'b1; ack_data = 3'b001;
    @(negedge clk);
    req_valid = 1'b0; ack_valid = 1'b0;
    chk("R11 set wins", 64'(stat), 64'(3'b001));
    ack(3'b111);

    // R13 single-cycle pulse
    req(1'b0, 26'h0000246, 32'h0);
    chk("R13 pulse high", 64'(dp_valid), 64'(1));
    @(negedge clk);
    chk("R13 pulse low", 64'(dp_valid), 64'(0));

    // R1 reset restores locks and clears tight (R7)
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 stat cleared", 64'(stat), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    req(1'b1, 26'h103F000, 32'h0);
    chk("R1 relocked after reset", 64'({dp_valid, stat}), 64'({1'b0, 3'b001}));
    ack(3'b111);
    req(1'b1, 26'h2000000, 32'h0E);
    ack(3'b111);
    req(1'b1, 26'h1002000, 32'h7);
    chk("R7 tight cleared by reset", 64'({dp_valid, stat}), 64'({1'b1, 3'b000}));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule